// File: doc/BRIEF.md
# Multi-Lane Deskew Release Buffer

This block lines up several received lanes so that they leave the receiver in the same cycle, at a point fixed to the multiframe clock. Each lane watches its decoded character stream for the start of the alignment sequence. The start is a /R/ control character that directly follows a /K/ control character. From that character on, the lane stores every character it receives in its own elastic FIFO.

A shared controller watches the multiframe count supplied from outside. Once at least one lane has started, it picks the first release point and opens all FIFOs together. With a zero offset the release point is the multiframe boundary. A non-zero offset moves it that many counts earlier.

The controller also reports how far before the next boundary the latest lane arrived, as the release buffer delay (RBD) count. This value guides how large the offset can safely be. If the buffers are opened before an enabled lane has started, a deskew error is raised. A resync input clears the whole block for a new alignment attempt.

Top module: `deskew_release_buf`

## Requirements
- R1: A lane starts only on a control character 0x1C (K flag 1) in the cycle right after a control character 0xBC (K flag 1). From that cycle on, it stores one character per cycle, beginning with the 0x1C.
- R2: The release point is the cycle where `mf_boundary` is high (offset 0), or where `mf_count` equals MF_LEN minus the offset (offset N > 0). Release happens at the first such point that is strictly later than the first enabled lane's start cycle.
- R3: `out_valid` is low up to and including the release cycle and rises in the next cycle. It then stays high until resync or reset.
- R4: In the first valid cycle, every enabled lane that started before the release cycle outputs 0x1C with K flag 1. After that, it outputs its stored characters in arrival order, one per cycle.
- R5: `rbd_count` takes the value MF_LEN minus `mf_count` (so MF_LEN when the count is 0), sampled in the cycle where the most recent lane started.
- R6: `deskew_err` is set if, in the release cycle, an enabled lane has not started in an earlier cycle. It is also set if an enabled lane starts after release.
- R7: `rbd_count`, `deskew_err` and `ovf_err` hold their values until `resync` or reset. Both `resync` and reset clear them, together with `out_valid`.
- R8: A lane whose `lane_en` bit is 0 never starts. It has no effect on release, `rbd_count` or `deskew_err`, and its outputs are 0.
- R9: Before release, a lane whose FIFO already holds FIFO_DEPTH (32) characters drops any further write and sets its `ovf_err` bit one cycle later.
- R10: After reset, `out_valid`, `rbd_count`, `deskew_err` and `ovf_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Active-low synchronous reset |
| resync | input | 1 | Clears all alignment state for a new attempt |
| lane_en | input | NUM_LANES | Per-lane enable |
| lane_data | input | NUM_LANES*8 | Decoded character per lane, lane i at bits [8i+7:8i] |
| lane_k | input | NUM_LANES | Control-character flag per lane |
| mf_count | input | $clog2(MF_LEN) | Free-running multiframe count |
| mf_boundary | input | 1 | High in the cycle where the multiframe count is 0 |
| rbd_offset | input | $clog2(MF_LEN) | Counts by which release is moved before the boundary |
| out_valid | output | 1 | Aligned outputs are valid |
| out_data | output | NUM_LANES*8 | Aligned character per lane |
| out_k | output | NUM_LANES | Aligned control flag per lane |
| rbd_count | output | $clog2(MF_LEN+1) | Counts from the latest lane's start to the next boundary |
| deskew_err | output | 1 | Release happened before an enabled lane was ready |
| ovf_err | output | NUM_LANES | Per-lane FIFO overflow before release |

## Verification
The assertions assume three things about the inputs. First, `mf_count` steps by one per cycle modulo MF_LEN. Second, `mf_boundary` is high exactly where that count is 0. Third, `rbd_offset` stays constant during an alignment attempt.

The bench keeps to all three. It derives the count and boundary from its own cycle index, and it changes the offset only while `resync` is asserted. The overflow test is the only stimulus that holds the count still. It does so on purpose, so that no release point ever arrives.

// File: rtl/deskew_pkg.sv
package deskew_pkg;
  localparam logic [7:0] SYM_K = 8'hBC;
  localparam logic [7:0] SYM_R = 8'h1C;

  function automatic logic is_k_sym(input logic [7:0] d, input logic k);
    return k && (d == SYM_K);
  endfunction

  function automatic logic is_r_sym(input logic [7:0] d, input logic k);
    return k && (d == SYM_R);
  endfunction
endpackage

// File: rtl/lane_aligner.sv
module lane_aligner
  import deskew_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 32   // power of two
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          resync,
  input  logic          en,
  input  logic [DW-1:0] data_in,
  input  logic          k_in,
  input  logic          released,
  output logic          started,
  output logic          arrive,
  output logic [DW-1:0] data_out,
  output logic          k_out,
  output logic          ovf
);
  localparam int AW = $clog2(DEPTH);

  logic [DW:0]  mem [DEPTH];
  logic [AW:0]  wr_ptr, rd_ptr, fill;
  logic         prev_k, is_k_now, is_r_now, do_wr, full, wr_en;

  assign is_k_now = is_k_sym(data_in, k_in);
  assign is_r_now = is_r_sym(data_in, k_in);
  assign arrive   = en && !started && prev_k && is_r_now;
  assign do_wr    = arrive || started;
  assign fill     = wr_ptr - rd_ptr;
  assign full     = !released && (fill == (AW+1)'(DEPTH));
  assign wr_en    = do_wr && !full;

  always_ff @(posedge clk) begin
    if (!rst_n || resync) begin
      prev_k  <= 1'b0;
      started <= 1'b0;
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      ovf     <= 1'b0;
    end else begin
      prev_k <= is_k_now;
      if (arrive)         started <= 1'b1;
      if (wr_en)          wr_ptr  <= wr_ptr + 1'b1;
      if (released)       rd_ptr  <= rd_ptr + 1'b1;
      if (do_wr && full)  ovf     <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr[AW-1:0]] <= {k_in, data_in};
  end

  logic [DW:0] rd_word;
  assign rd_word  = (released && en) ? mem[rd_ptr[AW-1:0]] : '0;
  assign data_out = rd_word[DW-1:0];
  assign k_out    = rd_word[DW];

  // R1
  start_after_k_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(started) |-> $past(is_r_now && en));

  // R9
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !resync) |=> wr_ptr == $past(wr_ptr));

  // R7
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !resync) |=> ovf);
endmodule

// File: rtl/release_ctrl.sv
module release_ctrl #(
  parameter int NL     = 4,
  parameter int MF_LEN = 8,
  localparam int CW    = $clog2(MF_LEN),
  localparam int RBW   = $clog2(MF_LEN + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           resync,
  input  logic [NL-1:0]  en,
  input  logic [NL-1:0]  started,
  input  logic [NL-1:0]  arrive,
  input  logic [CW-1:0]  mf_count,
  input  logic           mf_boundary,
  input  logic [CW-1:0]  offset,
  output logic           released,
  output logic [RBW-1:0] rbd_count,
  output logic           deskew_err
);
  // count at which release fires for a non-zero offset (offset clamped)
  function automatic logic [CW-1:0] rel_count(input logic [CW-1:0] off);
    int o;
    o = (int'(off) >= MF_LEN) ? MF_LEN - 1 : int'(off);
    return CW'(MF_LEN - o);
  endfunction

  // counts from a given multiframe count up to the next boundary
  function automatic logic [RBW-1:0] rbd_of(input logic [CW-1:0] cnt);
    return RBW'(MF_LEN - int'(cnt));
  endfunction

  logic          at_point, any_started, go;
  logic [NL-1:0] missing;

  assign at_point    = (offset == '0) ? mf_boundary : (mf_count == rel_count(offset));
  assign missing     = en & ~started;
  assign any_started = |(en & started);
  assign go          = !released && any_started && at_point;

  always_ff @(posedge clk) begin
    if (!rst_n || resync) begin
      released   <= 1'b0;
      rbd_count  <= '0;
      deskew_err <= 1'b0;
    end else begin
      if (go) released <= 1'b1;
      if ((go && |missing) || (released && |arrive)) deskew_err <= 1'b1;
      if (|arrive) rbd_count <= rbd_of(mf_count);
    end
  end

  // R3
  rel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (released && !resync) |=> released);

  // R2
  rel_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(released) |-> $past(at_point));

  // R6
  late_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && |missing && !resync) |=> deskew_err);

  // R7
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (deskew_err && !resync) |=> deskew_err);

  // R5
  rbd_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rbd_count <= RBW'(MF_LEN));
endmodule

// File: rtl/deskew_release_buf.sv
module deskew_release_buf #(
  parameter int NUM_LANES  = 4,
  parameter int MF_LEN     = 8,
  parameter int FIFO_DEPTH = 32,
  localparam int DW        = 8,
  localparam int CW        = $clog2(MF_LEN),
  localparam int RBW       = $clog2(MF_LEN + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    resync,
  input  logic [NUM_LANES-1:0]    lane_en,
  input  logic [NUM_LANES*DW-1:0] lane_data,
  input  logic [NUM_LANES-1:0]    lane_k,
  input  logic [CW-1:0]           mf_count,
  input  logic                    mf_boundary,
  input  logic [CW-1:0]           rbd_offset,
  output logic                    out_valid,
  output logic [NUM_LANES*DW-1:0] out_data,
  output logic [NUM_LANES-1:0]    out_k,
  output logic [RBW-1:0]          rbd_count,
  output logic                    deskew_err,
  output logic [NUM_LANES-1:0]    ovf_err
);
  logic [NUM_LANES-1:0] started, arrive;
  logic                 released;

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    lane_aligner #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .resync   (resync),
      .en       (lane_en[i]),
      .data_in  (lane_data[i*DW +: DW]),
      .k_in     (lane_k[i]),
      .released (released),
      .started  (started[i]),
      .arrive   (arrive[i]),
      .data_out (out_data[i*DW +: DW]),
      .k_out    (out_k[i]),
      .ovf      (ovf_err[i])
    );
  end

  release_ctrl #(.NL(NUM_LANES), .MF_LEN(MF_LEN)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .resync      (resync),
    .en          (lane_en),
    .started     (started),
    .arrive      (arrive),
    .mf_count    (mf_count),
    .mf_boundary (mf_boundary),
    .offset      (rbd_offset),
    .released    (released),
    .rbd_count   (rbd_count),
    .deskew_err  (deskew_err)
  );

  assign out_valid = released;

  // R8
  idle_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(started & ~lane_en & ~$past(lane_en)) == 0);
endmodule

// File: tb/deskew_release_buf_bench.sv
`timescale 1ns/1ps
module deskew_release_buf_bench;
  localparam int NL = 4;
  localparam int MF = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          resync = 1'b0;
  logic [NL-1:0] lane_en = '0;
  logic [NL*8-1:0] lane_data = '0;
  logic [NL-1:0] lane_k = '0;
  logic [2:0]    mf_count = '0;
  logic          mf_boundary = 1'b0;
  logic [2:0]    rbd_offset = '0;
  logic          out_valid;
  logic [NL*8-1:0] out_data;
  logic [NL-1:0] out_k;
  logic [3:0]    rbd_count;
  logic          deskew_err;
  logic [NL-1:0] ovf_err;

  int tests = 0;
  int fails = 0;
  int a_cur [NL];
  logic [NL-1:0] en_cur;
  int off_cur;

  always #10 clk = ~clk;

  deskew_release_buf u_deskew_release_buf (
    .clk(clk), .rst_n(rst_n), .resync(resync), .lane_en(lane_en),
    .lane_data(lane_data), .lane_k(lane_k), .mf_count(mf_count),
    .mf_boundary(mf_boundary), .rbd_offset(rbd_offset), .out_valid(out_valid),
    .out_data(out_data), .out_k(out_k), .rbd_count(rbd_count),
    .deskew_err(deskew_err), .ovf_err(ovf_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive lane i for cycle c: /K/ before start, /R/ at start, data after
  task automatic drive_lanes(input int c, input logic hold_k);
    for (int i = 0; i < NL; i++) begin
      if (hold_k || c < a_cur[i]) begin
        lane_data[i*8 +: 8] = 8'hBC; lane_k[i] = 1'b1;
      end else if (c == a_cur[i]) begin
        lane_data[i*8 +: 8] = 8'h1C; lane_k[i] = 1'b1;
      end else begin
        lane_data[i*8 +: 8] = 8'(i*40 + (c - a_cur[i])); lane_k[i] = 1'b0;
      end
    end
  endtask

  task automatic run_case();
    int min_a, max_a, relc, t_rel, last;
    bit err_exp;
    int rbd_exp;
    min_a = 1000; max_a = -1;
    for (int i = 0; i < NL; i++)
      if (en_cur[i]) begin
        if (a_cur[i] < min_a) min_a = a_cur[i];
        if (a_cur[i] > max_a) max_a = a_cur[i];
      end
    relc  = (off_cur == 0) ? 0 : MF - off_cur;
    t_rel = min_a + 1;
    while ((t_rel % MF) != relc) t_rel++;
    err_exp = 1'b0;
    for (int i = 0; i < NL; i++)
      if (en_cur[i] && a_cur[i] >= t_rel) err_exp = 1'b1;
    rbd_exp = MF - (max_a % MF);
    last = ((t_rel > max_a) ? t_rel : max_a) + 6;

    @(negedge clk);
    resync = 1'b1; rbd_offset = 3'(off_cur); lane_en = en_cur;
    mf_count = 3'(MF - 1); mf_boundary = 1'b0;
    drive_lanes(-1, 1'b1);
    for (int c = 0; c <= last; c++) begin
      @(negedge clk);
      if (c == 0) begin
        chk(rbd_count == 0 && !deskew_err && !out_valid, "R7 resync clears",
            {deskew_err, out_valid, rbd_count}, 0);
      end
      if (c == t_rel) chk(out_valid == 1'b0, "R3 valid low at release", out_valid, 0);
      if (c == t_rel + 1) begin
        chk(out_valid == 1'b1, "R2 release point", out_valid, 1);
        for (int i = 0; i < NL; i++)
          if (!en_cur[i])
            chk(out_data[i*8 +: 8] == 0 && !out_k[i], "R8 idle lane output",
                out_data[i*8 +: 8], 0);
      end
      if (c >= t_rel + 1 && c <= t_rel + 4) begin
        for (int i = 0; i < NL; i++)
          if (en_cur[i] && a_cur[i] < t_rel) begin
            int m;
            logic [8:0] exp_w;
            m = c - t_rel - 1;
            exp_w = (m == 0) ? 9'h11C : {1'b0, 8'(i*40 + m)};
            chk({out_k[i], out_data[i*8 +: 8]} == exp_w, "R4 aligned lane",
                {out_k[i], out_data[i*8 +: 8]}, exp_w);
          end
      end
      if (c == last) begin
        chk(rbd_count == 4'(rbd_exp), "R5 rbd count", rbd_count, rbd_exp);
        chk(deskew_err == err_exp, "R6 deskew error", deskew_err, err_exp);
        chk(out_valid == 1'b1, "R7 valid held", out_valid, 1);
      end
      resync = 1'b0;
      mf_count = 3'(c % MF);
      mf_boundary = ((c % MF) == 0);
      drive_lanes(c, 1'b0);
    end
  endtask

  task automatic run_overflow();
    for (int i = 0; i < NL; i++) a_cur[i] = 1000;
    a_cur[0] = 1;
    @(negedge clk);
    resync = 1'b1; rbd_offset = 3'd0; lane_en = 4'b0001;
    mf_count = 3'd5; mf_boundary = 1'b0;
    drive_lanes(-1, 1'b1);
    for (int c = 0; c <= 36; c++) begin
      @(negedge clk);
      if (c == 33) chk(ovf_err == 4'b0000, "R9 no overflow at full", ovf_err, 0);
      if (c == 34) chk(ovf_err == 4'b0001, "R9 overflow flag", ovf_err, 1);
      if (c == 36) chk(ovf_err == 4'b0001 && !out_valid, "R9 overflow held", ovf_err, 1);
      resync = 1'b0;
      drive_lanes(c, 1'b0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10
    chk(!out_valid && rbd_count == 0 && !deskew_err && ovf_err == 0,
        "R10 reset state", {out_valid, deskew_err, ovf_err}, 0);

    // R1 R2 R4: sweep offsets and skew patterns
    for (int off = 0; off < 4; off++)
      for (int s = 0; s < 4; s++)
        for (int b = 0; b < 3; b++) begin
          int base;
          base = (b == 0) ? 1 : (b == 1) ? 3 : 6;
          for (int i = 0; i < NL; i++) a_cur[i] = base + ((i * s) % 5);
          en_cur = 4'hF; off_cur = off;
          run_case();
        end

    // offset 1, all lanes at count 4: release at count 7, rbd 4
    for (int i = 0; i < NL; i++) a_cur[i] = 4;
    en_cur = 4'hF; off_cur = 1;
    run_case();

    // R6 late lane
    a_cur[0] = 2; a_cur[1] = 3; a_cur[2] = 2; a_cur[3] = 20;
    en_cur = 4'hF; off_cur = 1;
    run_case();

    // R8 disabled lane starting late is ignored
    a_cur[0] = 2; a_cur[1] = 5; a_cur[2] = 3; a_cur[3] = 25;
    en_cur = 4'b0111; off_cur = 2;
    run_case();

    // single enabled lane
    a_cur[0] = 9; a_cur[1] = 1; a_cur[2] = 1; a_cur[3] = 1;
    en_cur = 4'b0001; off_cur = 0;
    run_case();

    run_overflow();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule